// File: doc/BRIEF.md
# SIMD Compare and Lane Select

This unit treats each 64-bit operand as two independent 32-bit lanes. A compare command evaluates one relation per lane (equality, signed or unsigned greater-than, signed or unsigned less-than) and packs the two lane outcomes into a 4-bit condition field. The field also carries their OR and their AND, so a later branch or merge can test "either lane" or "both lanes" directly.

A select command takes a 4-bit condition field and two 64-bit operands, and builds a 64-bit result lane by lane. Each lane is copied from operand A when its own condition bit is set, and from operand B when it is clear. Both commands share one input port set. Their results are registered one cycle after a valid command. The output that a command does not produce keeps its last value.

Top module: `simd_cmp_sel`

## Requirements
- R1: In the condition field produced by a compare, bit 3 is the result for the high lane (bits 63:32) and bit 2 is the result for the low lane (bits 31:0).
- R2: Condition bit 1 is the OR of the two lane results, and bit 0 is their AND.
- R3: mode_i selects the relation applied to lane A versus lane B. 0 is equal, 1 is signed greater-than, 2 is unsigned greater-than, 3 is signed less-than, and 4 is unsigned less-than. The signed relations read a lane as two's complement.
- R4: mode_i values 5, 6 and 7 give a false result in both lanes, so the condition field is 4'b0000.
- R5: In a select, the high lane of data_o comes from opa_i[63:32] when cond_i[3] is 1, and from opb_i[63:32] when it is 0.
- R6: In a select, the low lane of data_o comes from opa_i[31:0] when cond_i[2] is 1, and from opb_i[31:0] when it is 0. cond_i[1:0] has no effect.
- R7: cmd_i=0 is a compare and updates only cond_o. cmd_i=1 is a select and updates only data_o. The other output keeps its value.
- R8: A command accepted with valid_i=1 at a rising edge shows its result, together with valid_o=1, after that edge. A cycle without valid_i leaves valid_o at 0 and both outputs unchanged.
- R9: While rst_ni is low, cond_o, data_o and valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Command valid |
| cmd_i | input | 1 | 0 compare, 1 select |
| mode_i | input | 3 | Compare relation |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| cond_i | input | 4 | Condition field used by select |
| valid_o | output | 1 | Result registered this cycle |
| cond_o | output | 4 | Condition field from the last compare |
| data_o | output | 64 | Data from the last select |

## Verification
A compare and a select can meet in one cycle. In that cycle the condition field of a compare has just reached cond_o, and the next command is a select that consumes that field through cond_i. The bench provokes this by issuing compares and selects back to back and by alternating the command type on every cycle. In each such cycle the scoreboard checks that the select's lane choice matches the field it was given, and that cond_o keeps the compare result while data_o changes.

// File: rtl/simd_cs_pkg.sv
package simd_cs_pkg;
  localparam int LANE_W  = 32;
  localparam int N_LANES = 2;
  localparam int DATA_W  = LANE_W * N_LANES;
  localparam int COND_W  = 4;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_GTS = 3'd1,
    CMP_GTU = 3'd2,
    CMP_LTS = 3'd3,
    CMP_LTU = 3'd4
  } cmp_mode_e;

  typedef enum logic {
    CMD_CMP = 1'b0,
    CMD_SEL = 1'b1
  } cmd_e;
endpackage

// File: rtl/lane_cmp.sv
module lane_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   mode_i,
  output logic         hit_o
);
  import simd_cs_pkg::*;

  logic eq, gtu, gts;

  assign eq  = (a_i == b_i);
  assign gtu = (a_i > b_i);
  assign gts = ($signed(a_i) > $signed(b_i));

  always_comb begin
    case (mode_i)
      CMP_EQ:  hit_o = eq;
      CMP_GTS: hit_o = gts;
      CMP_GTU: hit_o = gtu;
      CMP_LTS: hit_o = !gts && !eq;
      CMP_LTU: hit_o = !gtu && !eq;
      default: hit_o = 1'b0;  // unassigned codes never match
    endcase
  end
endmodule

// File: rtl/cond_pack.sv
module cond_pack (
  input  logic       hi_i,
  input  logic       lo_i,
  output logic [3:0] cond_o
);
  assign cond_o = {hi_i, lo_i, hi_i | lo_i, hi_i & lo_i};
endmodule

// File: rtl/lane_sel.sv
module lane_sel #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         pick_a_i,
  output logic [W-1:0] y_o
);
  assign y_o = pick_a_i ? a_i : b_i;
endmodule

// File: rtl/simd_cmp_sel.sv
module simd_cmp_sel
  import simd_cs_pkg::*;
#(
  parameter int LW = LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              cmd_i,
  input  logic [2:0]        mode_i,
  input  logic [2*LW-1:0]   opa_i,
  input  logic [2*LW-1:0]   opb_i,
  input  logic [3:0]        cond_i,
  output logic              valid_o,
  output logic [3:0]        cond_o,
  output logic [2*LW-1:0]   data_o
);
  localparam int NL = 2;
  localparam int DW = NL * LW;

  logic [NL-1:0] lane_hit;
  logic [DW-1:0] sel_data;
  logic [3:0]    cond_nxt;
  logic [1:0]    unused_cond;

  assign unused_cond = cond_i[1:0];

  // lane l reads condition bit 2+l (high lane -> bit 3)
  for (genvar l = 0; l < NL; l++) begin : g_lane
    lane_cmp #(.W(LW)) u_cmp (
      .a_i    (opa_i[l*LW +: LW]),
      .b_i    (opb_i[l*LW +: LW]),
      .mode_i (mode_i),
      .hit_o  (lane_hit[l])
    );
    lane_sel #(.W(LW)) u_sel (
      .a_i      (opa_i[l*LW +: LW]),
      .b_i      (opb_i[l*LW +: LW]),
      .pick_a_i (cond_i[2+l]),
      .y_o      (sel_data[l*LW +: LW])
    );
  end

  cond_pack u_pack (
    .hi_i   (lane_hit[1]),
    .lo_i   (lane_hit[0]),
    .cond_o (cond_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cond_o  <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i && cmd_i == CMD_CMP) cond_o <= cond_nxt;
      if (valid_i && cmd_i == CMD_SEL) data_o <= sel_data;
    end
  end

  // R8: valid_o follows an accepted command by one cycle
  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(cond_o) && $stable(data_o)));
  // R7: the output a command does not produce is held
  a_r7_cmp_holds_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmd_i == CMD_CMP) |=> $stable(data_o));
  a_r7_sel_holds_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmd_i == CMD_SEL) |=> $stable(cond_o));
  // R5 / R6: lane source follows its condition bit
  a_r5_hi_from_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmd_i == CMD_SEL && cond_i[3]) |=> data_o[DW-1:LW] == $past(opa_i[DW-1:LW]));
  a_r6_lo_from_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmd_i == CMD_SEL && !cond_i[2]) |=> data_o[LW-1:0] == $past(opb_i[LW-1:0]));
  // R1/R2: identical operands under equal set every field bit
  a_r1_eq_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmd_i == CMD_CMP && mode_i == CMP_EQ && opa_i == opb_i) |=> cond_o == 4'b1111);
  // R4: unassigned compare codes clear the field
  a_r4_bad_mode_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmd_i == CMD_CMP && mode_i > 3'd4) |=> cond_o == 4'b0000);
  // R2: AND implies OR in the stored field
  a_r2_and_implies_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_o[0] |-> cond_o[1]);
endmodule

// File: tb/tb_simd_cmp_sel.sv
module tb_simd_cmp_sel;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        cmd = 1'b0;
  logic [2:0]  mode = '0;
  logic [63:0] opa = '0, opb = '0;
  logic [3:0]  cond_in = '0;
  logic        valid_out;
  logic [3:0]  cond_out;
  logic [63:0] data_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [3:0]  cond;
    logic [63:0] data;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [3:0]  mdl_cond = '0;
  logic [63:0] mdl_data = '0;
  logic [3:0]  last_cond = '0;
  logic [63:0] last_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_cmp_sel dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cmd_i(cmd), .mode_i(mode),
    .opa_i(opa), .opb_i(opb), .cond_i(cond_in),
    .valid_o(valid_out), .cond_o(cond_out), .data_o(data_out)
  );

  function automatic bit rel(input logic [31:0] a, input logic [31:0] b, input logic [2:0] m);
    case (m)
      3'd0: return a == b;
      3'd1: return $signed(a) > $signed(b);
      3'd2: return a > b;
      3'd3: return $signed(a) < $signed(b);
      3'd4: return a < b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] exp_cond(input logic [63:0] a, input logic [63:0] b,
                                          input logic [2:0] m);
    bit h, l;
    h = rel(a[63:32], b[63:32], m);
    l = rel(a[31:0], b[31:0], m);
    return {h, l, h | l, h & l};
  endfunction

  task automatic check(input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_cmp(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b,
                        input string tag);
    exp_t e;
    @(negedge clk);
    valid = 1; cmd = 0; mode = m; opa = a; opb = b; cond_in = 4'hF;
    mdl_cond = exp_cond(a, b, m);
    e.cond = mdl_cond; e.data = mdl_data; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic do_sel(input logic [3:0] c, input logic [63:0] a, input logic [63:0] b,
                        input string tag);
    exp_t e;
    @(negedge clk);
    valid = 1; cmd = 1; mode = 3'd0; opa = a; opb = b; cond_in = c;
    mdl_data = {c[3] ? a[63:32] : b[63:32], c[2] ? a[31:0] : b[31:0]};
    e.cond = mdl_cond; e.data = mdl_data; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 0; opa = ~opa; cmd = ~cmd; mode = 3'd0; cond_in = ~cond_in;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
        last_cond = '0; last_data = '0;
        continue;
      end
      if (valid_out) begin
        if (sb.size() == 0) begin
          check("R8 unexpected valid_o", 68'd1, 68'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, {cond_out, data_out}, {e.cond, e.data});
          last_cond = e.cond; last_data = e.data;
        end
      end else begin
        check("R8 hold while idle", {cond_out, data_out}, {last_cond, last_data});
      end
    end
  end

  // watchdog
  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    // R9: outputs cleared under reset
    check("R9 reset state", {valid_out, 3'b0, cond_out, data_out}, 68'd0);
    @(negedge clk); rst_n = 1;
    idle(2);

    // R1 R2 R3: equal mode
    do_cmp(3'd0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, "R1 eq both lanes");
    do_cmp(3'd0, 64'h1234_5678_0000_0001, 64'h1234_5678_0000_0002, "R1 eq high only");
    do_cmp(3'd0, 64'h0000_0001_CAFE_0000, 64'h0000_0002_CAFE_0000, "R2 eq low only");
    // R3: signed vs unsigned
    do_cmp(3'd1, 64'hFFFF_FFFF_0000_0005, 64'h0000_0001_0000_0003, "R3 gts");
    do_cmp(3'd2, 64'hFFFF_FFFF_0000_0005, 64'h0000_0001_0000_0003, "R3 gtu");
    do_cmp(3'd3, 64'hFFFF_FFFF_0000_0005, 64'h0000_0001_0000_0003, "R3 lts");
    do_cmp(3'd4, 64'hFFFF_FFFF_0000_0005, 64'h0000_0001_0000_0003, "R3 ltu");
    do_cmp(3'd3, 64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, "R3 lts extremes");
    do_cmp(3'd1, 64'h0000_0007_0000_0007, 64'h0000_0007_0000_0007, "R3 gts equal is false");
    // R4: unassigned codes
    do_cmp(3'd5, 64'h0, 64'h0, "R4 mode 5");
    do_cmp(3'd6, 64'h1, 64'h0, "R4 mode 6");
    do_cmp(3'd7, 64'h0, 64'h1, "R4 mode 7");
    idle(3);

    // R5 R6: every condition value
    for (int c = 0; c < 16; c++)
      do_sel(c[3:0], 64'hAAAA_AAAA_1111_1111, 64'h5555_5555_2222_2222, "R5 R6 select sweep");
    idle(2);

    // R7: compare feeding select back to back, alternating commands
    for (int k = 0; k < 6; k++) begin
      logic [63:0] a, b;
      a = {32'(k * 3), 32'(7 - k)};
      b = {32'(9 - k), 32'(k)};
      do_cmp(3'(k % 5), a, b, "R7 compare keeps data");
      do_sel(exp_cond(a, b, 3'(k % 5)), a, b, "R7 select keeps cond");
    end
    idle(4);

    // R9: reset in mid run clears state
    @(negedge clk); rst_n = 0; sb.delete(); mdl_cond = '0; mdl_data = '0;
    #1 check("R9 mid-run reset", {valid_out, 3'b0, cond_out, data_out}, 68'd0);
    @(negedge clk); rst_n = 1;
    idle(2);
    do_sel(4'b0100, 64'hDEAD_BEEF_0BAD_F00D, 64'h0123_4567_89AB_CDEF, "R6 low from A after reset");
    idle(3);

    check("R8 scoreboard drained", 68'(sb.size()), 68'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule